// File: doc/BRIEF.md
# Interrupt Distributor Configuration Register Bank

This block is the software-visible configuration store of an interrupt distributor. It holds one priority byte per interrupt line and one CPU-target byte per line, plus three read-only identification words. A simple single-cycle bus reaches it: one request strobe, a write flag, a 12-bit byte address and four byte enables. Reads answer one cycle later. The number of lines, the number of CPUs and the number of implemented priority bits are parameters.

Stored values are trimmed as they are written. Priority bytes keep only their upper implemented bits. Target bytes keep only the bits of CPUs that exist. Words that lie past the configured line count read as zero and drop writes. The target bytes of the first 32 lines are not stored. Each such byte returns the bit of the CPU that makes the access.

Address layout: the identification words are at 0x000 (type), 0x004 (implementation ID) and 0x008 (peripheral ID 2). The priority bytes start at 0x400, with line n at byte offset 0x400+n. The target bytes start at 0x800, with line n at byte offset 0x800+n. Every other offset is unmapped. Byte lane b of a word holds line 4*w+b.

Top module: `irq_dist_regs`

## Requirements
- R1: A read of offset 0x000 returns the line count as NUM_LINES/32-1 in bits [4:0] and NUM_CPUS-1 in bits [7:5]; all other bits are zero.
- R2: The words at 0x000, 0x004 and 0x008 are read-only. A write to any of them leaves its read value unchanged, and 0x004 and 0x008 return the IMPL_ID and PERIPH_ID2 parameters.
- R3: A priority byte stores only its upper PRIO_BITS bits. The lower 8-PRIO_BITS bits always read as zero.
- R4: Priority masking is the same in all four lanes: writing 0xFFFFFFFF to a priority word reads back the same mask byte in each lane.
- R5: A target byte of line 32 or above stores only bits [NUM_CPUS-1:0]. Bits for absent CPUs read as zero.
- R6: Priority and target words whose first line is at or beyond NUM_LINES read as zero and ignore writes. The last implemented word is not disturbed by such writes.
- R7: A write changes only the byte lanes whose byte enable is set. A read always returns the whole word, whatever the byte enables are.
- R8: Target words for lines 0 to 31 ignore writes. Each of their bytes reads as 1 shifted left by the accessing CPU number (cpu_id).
- R9: rvalid is high in exactly the cycle after a read request, with rdata valid in that cycle. A write produces no rvalid.
- R10: Reads of unmapped offsets (0x00C to 0x3FF, and 0xC00 to 0xFFF) return zero.
- R11: After reset, all stored priority and target bytes read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address; bits [1:0] are ignored |
| be | input | 4 | Byte enables for writes, lane b = bits [8b+7:8b] |
| wdata | input | 32 | Write data |
| cpu_id | input | 3 | Number of the CPU making the access |
| rdata | output | 32 | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read response strobe |

## Verification
Every read result is due at the first rising edge after the request. A write takes effect at that same edge, so a read issued in the next cycle already sees it. The bench drives each access on a falling edge. It then compares rvalid and rdata at the following falling edge against a behavioural byte-array model, which predicts both the response of the access and the state it leaves behind. Write accesses are checked the same way, so a spurious rvalid after a write is caught in the cycle it would appear.

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int          NUM_LINES  = 64,
  parameter int          NUM_CPUS   = 4,
  parameter int          PRIO_BITS  = 5,
  parameter logic [31:0] IMPL_ID    = 32'h0201_043B,
  parameter logic [31:0] PERIPH_ID2 = 32'h0000_0020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [11:0] addr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [2:0]  cpu_id,
  output logic [31:0] rdata,
  output logic        rvalid
);
  localparam int NW = NUM_LINES / 4;
  localparam int NS = NUM_LINES - 32;
  localparam int NT = NS / 4;
  localparam int WW = $clog2(NW);
  localparam int TW = $clog2(NT);
  localparam logic [7:0] PMASK = 8'(8'hFF << (8 - PRIO_BITS));
  localparam logic [7:0] CMASK = 8'((1 << NUM_CPUS) - 1);
  localparam logic [31:0] TYPE_WORD = {24'd0, 3'(NUM_CPUS - 1), 5'(NUM_LINES / 32 - 1)};

  wire [7:0] widx   = addr[9:2];
  wire       rg_id  = addr[11:10] == 2'b00;
  wire       rg_pri = addr[11:10] == 2'b01;
  wire       rg_tgt = addr[11:10] == 2'b10;
  wire       in_range   = int'(widx) < NW;
  wire       pri_hit    = rg_pri && in_range;
  wire       tgt_local  = rg_tgt && widx < 8'd8;
  wire       tgt_shared = rg_tgt && !tgt_local && in_range;
  wire       do_wr      = req && wr;
  wire [7:0] toff       = widx - 8'd8;
  wire [WW-1:0] pidx    = widx[WW-1:0];
  wire [TW-1:0] tidx    = toff[TW-1:0];

  logic [7:0] prio_q [NUM_LINES];
  logic [7:0] tgt_q  [NS];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prio_q[i] <= 8'd0;
      else if (do_wr && pri_hit && pidx == WW'(i / 4) && be[i % 4])
        prio_q[i] <= wdata[8*(i%4) +: 8] & PMASK;
  end

  for (genvar j = 0; j < NS; j++) begin : g_tgt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tgt_q[j] <= 8'd0;
      else if (do_wr && tgt_shared && tidx == TW'(j / 4) && be[j % 4])
        tgt_q[j] <= wdata[8*(j%4) +: 8] & CMASK;
  end

  wire [7:0] self_bit = (8'd1 << cpu_id) & CMASK;

  logic [31:0] rd_word;
  always_comb begin
    rd_word = 32'd0;
    if (rg_id) begin
      case (widx)
        8'd0:    rd_word = TYPE_WORD;
        8'd1:    rd_word = IMPL_ID;
        8'd2:    rd_word = PERIPH_ID2;
        default: rd_word = 32'd0;
      endcase
    end else if (pri_hit)
      rd_word = {prio_q[{pidx, 2'd3}], prio_q[{pidx, 2'd2}], prio_q[{pidx, 2'd1}], prio_q[{pidx, 2'd0}]};
    else if (tgt_local)
      rd_word = {4{self_bit}};
    else if (tgt_shared)
      rd_word = {tgt_q[{tidx, 2'd3}], tgt_q[{tidx, 2'd2}], tgt_q[{tidx, 2'd1}], tgt_q[{tidx, 2'd0}]};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= 32'd0;
    end else begin
      rvalid <= req && !wr;
      if (req && !wr) rdata <= rd_word;
    end
endmodule

module irq_dist_regs_chk #(
  parameter int          NUM_LINES  = 64,
  parameter int          NUM_CPUS   = 4,
  parameter int          PRIO_BITS  = 5,
  parameter logic [31:0] IMPL_ID    = 32'h0201_043B,
  parameter logic [31:0] PERIPH_ID2 = 32'h0000_0020
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        wr,
  input logic [11:0] addr,
  input logic [31:0] rdata,
  input logic        rvalid
);
  localparam logic [7:0] PM = 8'(8'hFF << (8 - PRIO_BITS));
  localparam logic [7:0] CM = 8'((1 << NUM_CPUS) - 1);

  p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr) |=> rvalid);
  p_no_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !wr) |=> !rvalid);
  p_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(addr[11:2]) == 10'd0) |-> rdata == {24'd0, 3'(NUM_CPUS - 1), 5'(NUM_LINES / 32 - 1)});
  p_prio_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(addr[11:10]) == 2'b01) |-> (rdata & ~{4{PM}}) == 32'd0);
  p_tgt_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(addr[11:10]) == 2'b10) |-> (rdata & ~{4{CM}}) == 32'd0);
  p_beyond_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(addr[11]) != $past(addr[10]) && 4 * int'($past(addr[9:2])) >= NUM_LINES) |-> rdata == 32'd0);
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(addr[11:10]) == 2'b11) |-> rdata == 32'd0);
endmodule

bind irq_dist_regs irq_dist_regs_chk #(
  .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .PRIO_BITS(PRIO_BITS),
  .IMPL_ID(IMPL_ID), .PERIPH_ID2(PERIPH_ID2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/test_irq_dist_regs.sv
module test_irq_dist_regs;
  localparam int NL = 64;
  localparam int NC = 4;
  localparam int PB = 5;
  localparam logic [31:0] IID = 32'h0201_043B;
  localparam logic [31:0] PID = 32'h0000_0020;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  cpu_id = '0;
  logic [31:0] rdata;
  logic        rvalid;

  irq_dist_regs #(.NUM_LINES(NL), .NUM_CPUS(NC), .PRIO_BITS(PB), .IMPL_ID(IID), .PERIPH_ID2(PID))
    i_irq_dist_regs (.clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .be(be),
                     .wdata(wdata), .cpu_id(cpu_id), .rdata(rdata), .rvalid(rvalid));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int mprio [1024];
  int mtgt  [1024];
  int pm = (8'hFF << (8 - PB)) & 8'hFF;
  int cm = (1 << NC) - 1;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] model_read(input int a, input int cpu);
    logic [31:0] r = 0;
    if (a == 0) r = (NL / 32 - 1) | ((NC - 1) << 5);
    else if (a == 4) r = IID;
    else if (a == 8) r = PID;
    else if (a >= 'h400 && a < 'h800) begin
      int id = a - 'h400;
      if (id < NL) for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(mprio[id + b]);
    end else if (a >= 'h800 && a < 'hC00) begin
      int id = a - 'h800;
      if (id < 32) for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'((1 << cpu) & cm);
      else if (id < NL) for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(mtgt[id + b]);
    end
    return r;
  endfunction

  function automatic void model_write(input int a, input logic [3:0] e, input logic [31:0] d);
    for (int b = 0; b < 4; b++) if (e[b]) begin
      if (a >= 'h400 && a < 'h800 && a - 'h400 < NL) mprio[a - 'h400 + b] = d[8*b +: 8] & pm;
      if (a >= 'h820 && a < 'hC00 && a - 'h800 < NL) mtgt[a - 'h800 + b] = d[8*b +: 8] & cm;
    end
  endfunction

  task automatic op(input string tag, input bit w, input int a, input logic [3:0] e,
                    input logic [31:0] d, input int cpu);
    logic [31:0] exp_d;
    @(negedge clk);
    req = 1'b1; wr = w; addr = 12'(a); be = e; wdata = d; cpu_id = 3'(cpu);
    exp_d = model_read(a, cpu);
    if (w) model_write(a, e, d);
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    checks++;
    if (rvalid !== !w || (!w && rdata !== exp_d)) begin
      errors++;
      $display("FAIL %s addr=%03h: actual rvalid=%0b rdata=%08h expected rvalid=%0b rdata=%08h",
               tag, a, rvalid, rdata, !w, exp_d);
    end
  endtask

  task automatic rd(input string tag, input int a, input int cpu = 0);
    op(tag, 1'b0, a, 4'hF, 32'h0, cpu);
  endtask

  task automatic wrt(input string tag, input int a, input logic [3:0] e, input logic [31:0] d, input int cpu = 0);
    op(tag, 1'b1, a, e, d, cpu);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mprio[i] = 0; mtgt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset contents, R9 response timing
    rd("R11", 'h420); rd("R11", 'h43C); rd("R11", 'h820); rd("R11", 'h83C);
    // R1 type word, R2 identification words
    rd("R1", 'h000); rd("R2", 'h004); rd("R2", 'h008);
    wrt("R2", 'h000, 4'hF, 32'hFFFF_FFFF); rd("R2", 'h000);
    wrt("R2", 'h004, 4'hF, 32'h0); rd("R2", 'h004);
    wrt("R2", 'h008, 4'hF, 32'hA5A5_5A5A); rd("R2", 'h008);
    // R3 R4 priority masking
    wrt("R4", 'h420, 4'hF, 32'hFFFF_FFFF); rd("R4", 'h420);
    wrt("R3", 'h420, 4'hF, 32'hFF7F_BF3F); rd("R3", 'h420);
    wrt("R3", 'h404, 4'hF, 32'h0706_0501); rd("R3", 'h404);
    // R7 byte lanes
    wrt("R7", 'h420, 4'b0100, 32'h001F_0000); rd("R7", 'h420);
    wrt("R7", 'h420, 4'b0001, 32'hFFFF_FFF0); rd("R7", 'h420);
    op("R7", 1'b0, 'h420, 4'b0010, 32'h0, 0);
    // R5 target masking
    wrt("R5", 'h820, 4'hF, 32'hFFFF_FFFF); rd("R5", 'h820);
    wrt("R5", 'h820, 4'hF, 32'h0103_020F); rd("R5", 'h820);
    wrt("R7", 'h83C, 4'b1000, 32'h0500_0000); rd("R7", 'h83C);
    // R6 beyond the last line
    wrt("R6", 'h43C, 4'hF, 32'h8040_2010);
    wrt("R6", 'h440, 4'hF, 32'hFFFF_FFFF); rd("R6", 'h440); rd("R6", 'h43C);
    wrt("R6", 'h840, 4'hF, 32'hFFFF_FFFF); rd("R6", 'h840); rd("R6", 'h7FC); rd("R6", 'hBFC);
    // R8 private targets
    rd("R8", 'h800, 2); rd("R8", 'h81C, 3);
    wrt("R8", 'h800, 4'hF, 32'h0F0F_0F0F); rd("R8", 'h800, 0); rd("R8", 'h804, 1);
    // R10 unmapped
    rd("R10", 'h00C); rd("R10", 'h3FC); rd("R10", 'hC00); rd("R10", 'hFFC);
    // R9 back-to-back reads after writes
    wrt("R9", 'h424, 4'hF, 32'h1122_3344); rd("R9", 'h424); rd("R9", 'h420);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule